// File: doc/BRIEF.md
# PTP Event Frame Signature Extractor

This block sits on the transmit byte stream of an Ethernet port. It follows each outgoing frame one byte at a time and, when the frame carries a PTP event message, builds a 16-byte signature from fields of that frame. Logic elsewhere stores the signature next to the timestamp taken for the frame. Software later compares signatures to match each stored timestamp to the frame that produced it.

Two carriers are recognised. The first is PTP placed directly after the Ethernet header. The second is PTP inside IPv4/UDP, and the variable IPv4 header length is honoured. When a frame is decided, the block pulses one of two outputs for a single cycle. One pulse means a signature is ready. The other means that this frame will never yield one. The rest of the frame is then ignored until the next start of frame. Byte positions count from 0, where byte 0 is the byte accepted together with the start-of-frame marker. There is no VLAN tag handling.

Top module: `ptp_sig_extract`

## Requirements
- R1: A frame whose bytes 12 and 13 read 0x88 then 0xF7 is parsed as PTP over Ethernet, and its PTP header begins at byte 14.
- R2: A frame whose bytes 12 and 13 read 0x08 then 0x00 is examined as IPv4. Byte 14 must have version nibble 4 (bits 7:4) and a header-length nibble L (bits 3:0) of at least 5. Byte 23 must be 17 (UDP). The PTP header then begins at byte 14 + 4·L + 8, so IP options are skipped.
- R3: Any other EtherType, a version other than 4, a header length below 5, or a protocol other than 17 produces exactly one `unsup_o` pulse for that frame and no `sig_valid_o` pulse.
- R4: The signature is bytes 0..15, with byte k at `sig_o[127-8k -: 8]`. Byte 0 is PTP header byte 30 (sequence ID high). Byte 1 is PTP byte 31 (sequence ID low). Byte 2 is PTP byte 4 (domain). Byte 3 is {4'h0, bits 3:0 of PTP byte 0} (message type).
- R5: Signature bytes 4..9 are frame bytes 0..5, the destination MAC address, in the order they arrive.
- R6: Signature bytes 10..15 each equal {4'h0, message type}. The upper nibble of PTP byte 0 never reaches the signature.
- R7: `sig_valid_o` is high for exactly one cycle, namely the cycle after the sequence-ID low byte is accepted. `sig_o` keeps its value until the next `sig_valid_o` pulse.
- R8: If a frame ends (`in_eof` on an accepted byte) before its sequence-ID low byte, `unsup_o` pulses in the cycle after that byte. If `in_eof` arrives on the sequence-ID low byte itself, the frame is complete and gives a signature.
- R9: Cycles with `in_valid` low are ignored whatever the other inputs show. They do not shift byte positions, and no strobe follows them.
- R10: After a frame is decided, its remaining bytes, including its `in_eof`, cause nothing. A new start of frame restarts parsing at byte 0. An unfinished earlier frame is dropped without a strobe.
- R11: During and just after reset, `sig_o` is zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_eof | input | 1 | The present byte is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| sig_o | output | 128 | Signature of the most recent PTP event frame, byte 0 in the top bits |
| sig_valid_o | output | 1 | One-cycle pulse: `sig_o` has just been updated |
| unsup_o | output | 1 | One-cycle pulse: the current frame will not yield a signature |

## Verification
On every cycle, the assertions enforce several properties. The two strobes never coincide, and a signature pulse lasts a single cycle. The signature stays stable between pulses. No strobe follows a cycle without a valid byte. Once IPv4 has been accepted, the computed PTP start offset never points inside the Ethernet header. Other behaviour is shown only by the bench scenarios. These cover the exact value of each signature byte, the offset shift that IPv4 options cause, the single verdict for each rejection class, the boundary where `in_eof` meets the sequence-ID low byte, and the abandoning of a frame on a repeated start of frame.

// File: rtl/ptpsig_pkg.sv
package ptpsig_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned SIG_BYTES   = 16;
  localparam int unsigned SIG_W       = SIG_BYTES * BYTE_W;
  localparam int unsigned MAC_BYTES   = 6;
  localparam int unsigned MAC_W       = MAC_BYTES * BYTE_W;
  localparam int unsigned PAD_BYTES   = SIG_BYTES - 4 - MAC_BYTES;

  // Header geometry
  localparam int unsigned ETH_HDR_LEN = 14;
  localparam int unsigned UDP_HDR_LEN = 8;
  localparam int unsigned IP_PROTO_OFS = 9;
  localparam int unsigned IP_MIN_IHL  = 5;
  localparam logic [3:0]  IP_VERSION4 = 4'd4;
  localparam logic [7:0]  IP_PROTO_UDP = 8'd17;
  localparam logic [15:0] ETYPE_PTP   = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4  = 16'h0800;

  // Field offsets inside the PTP common header
  localparam int unsigned PTP_OFS_TYPE   = 0;
  localparam int unsigned PTP_OFS_DOMAIN = 4;
  localparam int unsigned PTP_OFS_SEQ_HI = 30;
  localparam int unsigned PTP_OFS_SEQ_LO = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ETH  = 2'd1,
    ST_IP   = 2'd2,
    ST_PTP  = 2'd3
  } parse_st_e;

  // Byte k of the signature sits at [SIG_W-1-8k -: 8]
  function automatic logic [SIG_W-1:0] pack_sig(input logic [15:0]      seq,
                                                input logic [7:0]       dom,
                                                input logic [3:0]       mtype,
                                                input logic [MAC_W-1:0] mac);
    logic [SIG_W-1:0] s;
    s = '0;
    s[SIG_W-1  -: 16]    = seq;
    s[SIG_W-17 -: 8]     = dom;
    s[SIG_W-25 -: 8]     = {4'h0, mtype};
    s[SIG_W-33 -: MAC_W] = mac;
    for (int k = 0; k < PAD_BYTES; k++) begin
      s[8*k +: 8] = {4'h0, mtype};
    end
    return s;
  endfunction

endpackage

// File: rtl/ptpsig_cursor.sv
module ptpsig_cursor #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             start,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Position of the byte on the bus this cycle
  assign idx    = start ? '0 : cnt_q;
  assign cnt_en = beat;

  always_comb begin
    cnt_d = (idx == IDX_MAX) ? idx : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ptpsig_classify.sv
module ptpsig_classify
  import ptpsig_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             start,
  input  logic             eof,
  input  logic [7:0]       data,
  input  logic [IDX_W-1:0] idx,
  input  logic             done,
  output logic             in_ptp,
  output logic             mac_phase,
  output logic             fail,
  output logic [IDX_W-1:0] base
);

  localparam logic [IDX_W-1:0] IX_ET_HI    = IDX_W'(ETH_HDR_LEN - 2);
  localparam logic [IDX_W-1:0] IX_ET_LO    = IDX_W'(ETH_HDR_LEN - 1);
  localparam logic [IDX_W-1:0] IX_IP_VER   = IDX_W'(ETH_HDR_LEN);
  localparam logic [IDX_W-1:0] IX_IP_PROTO = IDX_W'(ETH_HDR_LEN + IP_PROTO_OFS);
  localparam logic [IDX_W-1:0] IX_MAC_END  = IDX_W'(MAC_BYTES);
  localparam logic [IDX_W-1:0] L2_BASE     = IDX_W'(ETH_HDR_LEN);
  localparam logic [IDX_W-1:0] IP_FIXED    = IDX_W'(ETH_HDR_LEN + UDP_HDR_LEN);

  parse_st_e        st_q, st_d, eff_st;
  logic [7:0]       et_hi_q, et_hi_d;
  logic [3:0]       ihl_q, ihl_d;
  logic [IDX_W-1:0] base_q, base_d;
  logic             live, bad;

  assign eff_st    = start ? ST_ETH : st_q;
  assign live      = beat && (eff_st != ST_IDLE);
  assign in_ptp    = live && (eff_st == ST_PTP);
  assign mac_phase = live && (eff_st == ST_ETH) && (idx < IX_MAC_END);
  assign base      = base_q;

  always_comb begin
    st_d    = st_q;
    et_hi_d = et_hi_q;
    ihl_d   = ihl_q;
    base_d  = base_q;
    bad     = 1'b0;
    if (live) begin
      st_d = eff_st;
      unique case (eff_st)
        ST_ETH: begin
          if (idx == IX_ET_HI) et_hi_d = data;
          if (idx == IX_ET_LO) begin
            if ({et_hi_q, data} == ETYPE_PTP) begin
              st_d   = ST_PTP;
              base_d = L2_BASE;
            end else if ({et_hi_q, data} == ETYPE_IPV4) begin
              st_d = ST_IP;
            end else begin
              bad = 1'b1;
            end
          end
        end
        ST_IP: begin
          if (idx == IX_IP_VER) begin
            if (data[7:4] == IP_VERSION4 && data[3:0] >= 4'(IP_MIN_IHL)) ihl_d = data[3:0];
            else bad = 1'b1;
          end
          if (idx == IX_IP_PROTO) begin
            if (data == IP_PROTO_UDP) begin
              st_d   = ST_PTP;
              base_d = IP_FIXED + IDX_W'({ihl_q, 2'b00});
            end else begin
              bad = 1'b1;
            end
          end
        end
        ST_PTP: begin
          if (done) st_d = ST_IDLE;
        end
        default: ;
      endcase
      if (bad || eof) st_d = ST_IDLE;
    end
    fail = live && (bad || (eof && !done));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      et_hi_q <= '0;
      ihl_q   <= '0;
      base_q  <= '0;
    end else if (beat) begin
      st_q    <= st_d;
      et_hi_q <= et_hi_d;
      ihl_q   <= ihl_d;
      base_q  <= base_d;
    end
  end

  // PTP offset chosen for either carrier lies past the Ethernet header (R1, R2)
  assert_ptp_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PTP) |-> (base_q >= L2_BASE));

endmodule

// File: rtl/ptpsig_capture.sv
module ptpsig_capture
  import ptpsig_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_ptp,
  input  logic             mac_phase,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] base,
  input  logic [7:0]       data,
  output logic             done,
  output logic [SIG_W-1:0] sig_next
);

  localparam logic [IDX_W-1:0] REL_TYPE   = IDX_W'(PTP_OFS_TYPE);
  localparam logic [IDX_W-1:0] REL_DOMAIN = IDX_W'(PTP_OFS_DOMAIN);
  localparam logic [IDX_W-1:0] REL_SEQ_HI = IDX_W'(PTP_OFS_SEQ_HI);
  localparam logic [IDX_W-1:0] REL_SEQ_LO = IDX_W'(PTP_OFS_SEQ_LO);

  logic [IDX_W-1:0] rel;
  logic [MAC_W-1:0] mac_q, mac_d;
  logic [3:0]       mtype_q, mtype_d;
  logic [7:0]       dom_q, dom_d;
  logic [7:0]       seqhi_q, seqhi_d;
  logic             mac_en, fld_en;

  assign rel    = idx - base;
  assign done   = in_ptp && (rel == REL_SEQ_LO);
  assign mac_en = mac_phase;
  assign fld_en = in_ptp;

  always_comb begin
    mac_d   = {mac_q[MAC_W-BYTE_W-1:0], data};
    mtype_d = (rel == REL_TYPE)   ? data[3:0] : mtype_q;
    dom_d   = (rel == REL_DOMAIN) ? data      : dom_q;
    seqhi_d = (rel == REL_SEQ_HI) ? data      : seqhi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q   <= '0;
      mtype_q <= '0;
      dom_q   <= '0;
      seqhi_q <= '0;
    end else begin
      if (mac_en) mac_q <= mac_d;
      if (fld_en) begin
        mtype_q <= mtype_d;
        dom_q   <= dom_d;
        seqhi_q <= seqhi_d;
      end
    end
  end

  assign sig_next = pack_sig({seqhi_q, data}, dom_q, mtype_q, mac_q);

endmodule

// File: rtl/ptp_sig_extract.sv
module ptp_sig_extract
  import ptpsig_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic [SIG_W-1:0] sig_o,
  output logic             sig_valid_o,
  output logic             unsup_o
);

  logic             beat, start;
  logic [IDX_W-1:0] idx, base;
  logic             in_ptp, mac_phase, fail, done;
  logic [SIG_W-1:0] sig_next, sig_q, sig_d;
  logic             vld_q, uns_q;

  assign beat  = in_valid;
  assign start = in_valid & in_sof;

  ptpsig_cursor #(.IDX_W(IDX_W)) cursor_i (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .start (start),
    .idx   (idx)
  );

  ptpsig_classify #(.IDX_W(IDX_W)) classify_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .start     (start),
    .eof       (in_eof),
    .data      (in_data),
    .idx       (idx),
    .done      (done),
    .in_ptp    (in_ptp),
    .mac_phase (mac_phase),
    .fail      (fail),
    .base      (base)
  );

  ptpsig_capture #(.IDX_W(IDX_W)) capture_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ptp    (in_ptp),
    .mac_phase (mac_phase),
    .idx       (idx),
    .base      (base),
    .data      (in_data),
    .done      (done),
    .sig_next  (sig_next)
  );

  always_comb begin
    sig_d = done ? sig_next : sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
      vld_q <= 1'b0;
      uns_q <= 1'b0;
    end else begin
      sig_q <= sig_d;
      vld_q <= done;
      uns_q <= fail;
    end
  end

  assign sig_o       = sig_q;
  assign sig_valid_o = vld_q;
  assign unsup_o     = uns_q;

  assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sig_valid_o && unsup_o));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid_o |=> !sig_valid_o);

  assert_sig_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_valid_o |-> $stable(sig_o));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!sig_valid_o && !unsup_o));

  assert_strobe_has_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_valid_o || unsup_o) |-> $past(in_valid));

endmodule

// File: tb/ptp_sig_extract_tb_top.sv
module ptp_sig_extract_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk;
  logic         rst_n;
  logic         in_valid, in_sof, in_eof;
  logic [7:0]   in_data;
  logic [127:0] sig_o;
  logic         sig_valid_o, unsup_o;

  ptp_sig_extract dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .in_data     (in_data),
    .sig_o       (sig_o),
    .sig_valid_o (sig_valid_o),
    .unsup_o     (unsup_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Strobe monitor, sampled on the falling edge
  int           n_ok = 0;
  int           n_bad = 0;
  logic [127:0] got_sig = '0;
  int unsigned  pulse_cyc = 0;
  always @(negedge clk) begin
    if (sig_valid_o) begin
      n_ok++;
      got_sig = sig_o;
      pulse_cyc = cyc;
    end
    if (unsup_o) n_bad++;
  end

  typedef struct packed {
    logic [15:0] etype;
    logic [7:0]  verihl;
    logic [7:0]  proto;
    logic [7:0]  len;     // 0: full frame
    logic [15:0] seq;
    logic [7:0]  dom;
    logic [7:0]  tsmt;
    logic [47:0] mac;
    logic        gaps;
    logic        exp_ok;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h88F7, 8'h00, 8'h00, 8'd0,  16'h1234, 8'h05, 8'h12, 48'h0011223344AA, 1'b0, 1'b1, 8'd1},  // R1
    '{16'h0800, 8'h45, 8'h11, 8'd0,  16'hBEEF, 8'h7F, 8'h00, 48'h01005E00006B, 1'b0, 1'b1, 8'd2},  // R2
    '{16'h0800, 8'h48, 8'h11, 8'd0,  16'h0A0B, 8'h18, 8'h33, 48'hFFEEDDCCBBAA, 1'b1, 1'b1, 8'd2},  // R2 options
    '{16'h88F7, 8'h00, 8'h00, 8'd0,  16'hFFFF, 8'hC8, 8'hF9, 48'h0A1B2C3D4E5F, 1'b1, 1'b1, 8'd9},  // R9 gaps
    '{16'h86DD, 8'h00, 8'h00, 8'd0,  16'h1111, 8'h01, 8'h01, 48'h111111111111, 1'b0, 1'b0, 8'd3},  // R3
    '{16'h0800, 8'h65, 8'h11, 8'd0,  16'h2222, 8'h02, 8'h02, 48'h222222222222, 1'b0, 1'b0, 8'd3},  // R3 version
    '{16'h0800, 8'h45, 8'h06, 8'd0,  16'h3333, 8'h03, 8'h03, 48'h333333333333, 1'b0, 1'b0, 8'd3},  // R3 protocol
    '{16'h0800, 8'h43, 8'h11, 8'd0,  16'h4444, 8'h04, 8'h04, 48'h444444444444, 1'b0, 1'b0, 8'd3},  // R3 short IHL
    '{16'h88F7, 8'h00, 8'h00, 8'd40, 16'h5555, 8'h05, 8'h05, 48'h555555555555, 1'b0, 1'b0, 8'd8},  // R8
    '{16'h88F7, 8'h00, 8'h00, 8'd46, 16'h6789, 8'h2A, 8'h08, 48'h665544332211, 1'b0, 1'b1, 8'd8},  // R8 eof on seq lo
    '{16'h0800, 8'h45, 8'h11, 8'd73, 16'h7777, 8'h07, 8'h07, 48'h777777777777, 1'b0, 1'b0, 8'd8},  // R8 one short
    '{16'h88F7, 8'h00, 8'h00, 8'd12, 16'h8888, 8'h08, 8'h08, 48'h888888888888, 1'b0, 1'b0, 8'd8},  // R8 no ethertype
    '{16'h0800, 8'h4F, 8'h11, 8'd0,  16'h9ABC, 8'h63, 8'h0B, 48'h9988776655AA, 1'b0, 1'b1, 8'd2}   // R2 max IHL
  };

  logic [7:0]  fb [128];
  int          fb_len;
  int          seqlo_idx;
  int unsigned seqlo_cyc;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  function automatic logic [127:0] exp_sig(input vec_t v);
    logic [7:0]   b [16];
    logic [127:0] s;
    b[0] = v.seq[15:8];
    b[1] = v.seq[7:0];
    b[2] = v.dom;
    b[3] = {4'h0, v.tsmt[3:0]};
    for (int k = 0; k < 6; k++) b[4+k] = v.mac[47-8*k -: 8];
    for (int k = 10; k < 16; k++) b[k] = {4'h0, v.tsmt[3:0]};
    for (int k = 0; k < 16; k++) s[127-8*k -: 8] = b[k];
    return s;
  endfunction

  task automatic build(input vec_t v);
    int base;
    base = 14;
    for (int i = 0; i < 128; i++) fb[i] = 8'(8'hC3 ^ i);
    for (int i = 0; i < 6; i++) fb[i] = v.mac[47-8*i -: 8];
    fb[12] = v.etype[15:8];
    fb[13] = v.etype[7:0];
    if (v.etype == 16'h0800) begin
      fb[14] = v.verihl;
      fb[23] = v.proto;
      base = 14 + 4 * int'(v.verihl[3:0]) + 8;
    end
    fb[base]      = v.tsmt;
    fb[base + 4]  = v.dom;
    fb[base + 30] = v.seq[15:8];
    fb[base + 31] = v.seq[7:0];
    seqlo_idx = base + 31;
    fb_len = (v.len == 8'd0) ? base + 40 : int'(v.len);
  endtask

  task automatic drive_idle(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = junk;
      in_eof   = junk;
      in_data  = junk ? 8'hA5 : 8'h00;
    end
  endtask

  task automatic send_frame(input bit gaps, input bit with_eof);
    for (int i = 0; i < fb_len; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 2)) begin
        in_valid = 1'b0;
        in_sof   = 1'b1;
        in_eof   = 1'b1;
        in_data  = 8'hFF;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == fb_len - 1);
      in_data  = fb[i];
      if (i == seqlo_idx) seqlo_cyc = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    in_data  = 8'h00;
  endtask

  task automatic check(input bit ok, input int req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    vec_t v;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(negedge clk);
    check(sig_o == '0 && !sig_valid_o && !unsup_o, 11, "reset state (R11)",
          {sig_o[125:0], sig_valid_o, unsup_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sig_o == '0 && !sig_valid_o && !unsup_o, 11, "after reset (R11)",
          {sig_o[125:0], sig_valid_o, unsup_o}, '0);

    // Table walk
    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      build(v);
      n_ok = 0;
      n_bad = 0;
      send_frame(v.gaps, 1'b1);
      drive_idle(4, 1'b0);
      if (v.exp_ok) begin
        check(n_ok == 1 && n_bad == 0, int'(v.req), "verdict valid",
              128'(n_ok * 16 + n_bad), 128'(16));
        check(got_sig == exp_sig(v), int'(v.req), "signature R4 R5 R6",
              got_sig, exp_sig(v));
        check(pulse_cyc == seqlo_cyc + 1, 7, "pulse timing R7",
              128'(pulse_cyc), 128'(seqlo_cyc + 1));
      end else begin
        check(n_ok == 0 && n_bad == 1, int'(v.req), "verdict unsupported R10",
              128'(n_ok * 16 + n_bad), 128'(1));
      end
    end

    // R10: a second start of frame abandons an unfinished frame
    build(VECS[1]);
    fb_len = 20;
    n_ok = 0;
    n_bad = 0;
    send_frame(1'b0, 1'b0);
    build(VECS[0]);
    send_frame(1'b0, 1'b1);
    drive_idle(4, 1'b0);
    check(n_ok == 1 && n_bad == 0, 10, "restart on SOF",
          128'(n_ok * 16 + n_bad), 128'(16));
    check(got_sig == exp_sig(VECS[0]), 10, "restart signature", got_sig, exp_sig(VECS[0]));

    // R9 and R7: idle cycles showing SOF/EOF without valid change nothing
    drive_idle(12, 1'b1);
    drive_idle(2, 1'b0);
    check(n_ok == 1 && n_bad == 0, 9, "junk while idle",
          128'(n_ok * 16 + n_bad), 128'(16));
    check(sig_o == exp_sig(VECS[0]), 7, "signature held", sig_o, exp_sig(VECS[0]));

    // R8: one-byte frame
    build(VECS[0]);
    fb_len = 1;
    seqlo_idx = -1;
    n_ok = 0;
    n_bad = 0;
    send_frame(1'b0, 1'b1);
    drive_idle(3, 1'b0);
    check(n_ok == 0 && n_bad == 1, 8, "single-byte frame",
          128'(n_ok * 16 + n_bad), 128'(1));
    check(sig_o == exp_sig(VECS[0]), 7, "signature kept after reject", sig_o, exp_sig(VECS[0]));

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule